// File: doc/BRIEF.md
# Serial MII Segment Transmitter

This block turns a byte stream from a MAC receive path into the single-wire serial MII format. Each segment is ten bits long: a carrier bit, a data-valid bit, then eight payload bits. One bit leaves on every reference clock cycle, and a one-cycle sync strobe marks the first bit of each segment. At 100 Mb/s a new segment follows the previous one with no gap. At 10 Mb/s every segment is sent ten times in a row.

A byte is offered on `in_data` with `in_valid`. The block takes it only in the cycle where `in_ready` is high, which is the last bit of the final copy of the current segment. The byte then appears in the next segment with the data-valid bit set. If no byte is taken at a boundary, the payload carries in-band status instead: the speed, duplex, link and jabber indications. The speed select is sampled only at a boundary, so the copy count of a segment is fixed from its first bit to its last.

Top module: `smii_seg_tx`

## Requirements
- R1: A segment is sent in this order. Bit 0 is the carrier (`crs`) value. Bit 1 is the data-valid flag, which is 1 when a byte was taken at the preceding boundary. Bits 2..9 are the payload, least significant bit first.
- R2: When no byte is taken, the data-valid bit is 0 and the payload holds status. Payload bit 0 is speed (1 = 100 Mb/s, using the newly latched speed). Bit 1 is `full_duplex`, bit 2 is `link_up`, bit 3 is `jabber`, and bits 4..7 are 0.
- R3: `sync_out` is high for exactly one cycle, on the first bit of every segment, including every repeated copy at 10 Mb/s. Consecutive sync pulses are exactly 10 cycles apart.
- R4: With the latched speed at 100 Mb/s (`speed_100` = 1), each segment is sent once, and the next segment starts in the following cycle.
- R5: With the latched speed at 10 Mb/s (`speed_100` = 0), each segment is sent ten consecutive times with identical content.
- R6: `in_ready` is high only in the last bit cycle of the final copy of a segment. A byte is consumed only when `in_valid` and `in_ready` are both high. A byte held valid during the other cycles does not change the segment being sent.
- R7: `speed_100` is sampled only at a segment boundary. A change in the middle of a segment does not change that segment's copy count.
- R8: While `rst_n` is low, and in the first segment after reset, `ser_out` is 0. During reset `sync_out` is 1 and `in_ready` is 0. The latched speed after reset is 100 Mb/s, so `in_ready` first rises in the tenth cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one serial bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_100 | input | 1 | Speed select: 1 = 100 Mb/s, 0 = 10 Mb/s |
| crs | input | 1 | Carrier indication placed in segment bit 0 |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Byte is taken in this cycle if in_valid is high |
| link_up | input | 1 | Link status for idle segments |
| full_duplex | input | 1 | Duplex status for idle segments |
| jabber | input | 1 | Jabber / false-carrier flag for idle segments |
| ser_out | output | 1 | Serial segment data |
| sync_out | output | 1 | Segment start strobe |

## Verification
The bench captures complete segments bit by bit and compares them with hand-computed words. A design that reversed the payload order, or swapped the carrier and data-valid positions, would produce a different word. The bench holds `in_valid` high through the repeated copies at 10 Mb/s. A design that took bytes at every copy boundary would change content between copies and raise `in_ready` too early. The bench also flips the speed select partway through a 10 Mb/s segment. A design that sampled the speed directly would cut the repeat run short, or would report the wrong speed bit in the next status segment. Finally, the bench asserts reset in the middle of a segment and checks that the first segment after reset is all zero and is sent at 100 Mb/s timing.

// File: rtl/smii_tx_pkg.sv
package smii_tx_pkg;
    // Position of each status flag inside the idle payload
    localparam int ST_SPEED  = 0;
    localparam int ST_DUPLEX = 1;
    localparam int ST_LINK   = 2;
    localparam int ST_JABBER = 3;
    localparam int ST_FLAGS  = 4;

    // Fixed header positions inside a segment
    localparam int HDR_CRS   = 0;
    localparam int HDR_DV    = 1;
    localparam int HDR_W     = 2;

    typedef enum logic {
        SPD_10  = 1'b0,
        SPD_100 = 1'b1
    } speed_e;
endpackage

// File: rtl/seg_timer.sv
module seg_timer #(
    parameter int SEG_W  = 10,
    parameter int REPEAT = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast,
    output logic first_bit,
    output logic seg_end,
    output logic [$clog2(SEG_W)-1:0] bit_idx
);
    localparam int BIT_W = $clog2(SEG_W);
    localparam int REP_W = (REPEAT > 1) ? $clog2(REPEAT) : 1;

    typedef struct packed {
        logic [BIT_W-1:0] bits;
        logic [REP_W-1:0] reps;
    } tstate_t;

    tstate_t st_d, st_q;
    logic    last_bit;
    logic    last_rep;

    always_comb begin
        last_bit = (st_q.bits == BIT_W'(SEG_W - 1));
        last_rep = fast || (st_q.reps == REP_W'(REPEAT - 1));
        seg_end  = last_bit && last_rep;
        st_d     = st_q;
        if (last_bit) begin
            st_d.bits = '0;
            st_d.reps = seg_end ? '0 : st_q.reps + REP_W'(1);
        end else begin
            st_d.bits = st_q.bits + BIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign first_bit = (st_q.bits == '0);
    assign bit_idx   = st_q.bits;
endmodule

// File: rtl/seg_compose.sv
module seg_compose
    import smii_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int SEG_W = DATA_W + HDR_W
) (
    input  logic              crs,
    input  logic              take,
    input  logic [DATA_W-1:0] data,
    input  logic              fast,
    input  logic              full_duplex,
    input  logic              link_up,
    input  logic              jabber,
    output logic [SEG_W-1:0]  seg
);
    logic [DATA_W-1:0] status;
    logic [ST_FLAGS-1:0] flags;

    always_comb begin
        flags            = '0;
        flags[ST_SPEED]  = fast;
        flags[ST_DUPLEX] = full_duplex;
        flags[ST_LINK]   = link_up;
        flags[ST_JABBER] = jabber;
    end

    // Spread the status flags into the payload; upper bits stay zero
    for (genvar i = 0; i < DATA_W; i++) begin : g_status
        if (i < ST_FLAGS) begin : g_flag
            assign status[i] = flags[i];
        end else begin : g_zero
            assign status[i] = 1'b0;
        end
    end

    always_comb begin
        seg         = '0;
        seg[HDR_CRS] = crs;
        seg[HDR_DV]  = take;
        seg[SEG_W-1:HDR_W] = take ? data : status;
    end
endmodule

// File: rtl/smii_seg_tx.sv
module smii_seg_tx
    import smii_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int REPEAT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              speed_100,
    input  logic              crs,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              link_up,
    input  logic              full_duplex,
    input  logic              jabber,
    output logic              ser_out,
    output logic              sync_out
);
    localparam int SEG_W = DATA_W + HDR_W;
    localparam int BIT_W = $clog2(SEG_W);

    typedef struct packed {
        logic [SEG_W-1:0] seg;
        speed_e           spd;
    } state_t;

    state_t           st_d, st_q;
    logic             first_bit;
    logic             seg_end;
    logic [BIT_W-1:0] bit_idx;
    logic [SEG_W-1:0] next_seg;
    logic             take;
    logic             spd_latched;
    speed_e           spd_next;

    assign spd_latched = (st_q.spd == SPD_100);

    seg_timer #(
        .SEG_W (SEG_W),
        .REPEAT(REPEAT)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast     (spd_latched),
        .first_bit(first_bit),
        .seg_end  (seg_end),
        .bit_idx  (bit_idx)
    );

    assign take     = in_valid && seg_end;
    assign spd_next = speed_100 ? SPD_100 : SPD_10;

    seg_compose #(
        .DATA_W(DATA_W)
    ) u_compose (
        .crs        (crs),
        .take       (take),
        .data       (in_data),
        .fast       (spd_next == SPD_100),
        .full_duplex(full_duplex),
        .link_up    (link_up),
        .jabber     (jabber),
        .seg        (next_seg)
    );

    always_comb begin
        st_d = st_q;
        if (seg_end) begin
            st_d.seg = next_seg;
            st_d.spd = spd_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seg <= '0;
            st_q.spd <= SPD_100;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_out  = st_q.seg[bit_idx];
    assign sync_out = first_bit;
    assign in_ready = seg_end;
endmodule

// File: rtl/smii_seg_tx_chk.sv
module smii_seg_tx_chk #(
    parameter int SEG_W = 10
) (
    input logic clk,
    input logic rst_n,
    input logic sync_out,
    input logic ser_out,
    input logic in_ready,
    input logic in_valid,
    input logic spd_latched
);
    localparam int CW = $clog2(SEG_W + 1);
    logic [CW-1:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        since_q <= CW'(SEG_W);
        else if (sync_out) since_q <= CW'(1);
        else               since_q <= since_q + CW'(1);
    end

    // R3: sync exactly every SEG_W cycles
    a_r3_sync_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out == (since_q == CW'(SEG_W)));

    // R3: sync lasts a single cycle
    a_r3_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
        sync_out |=> !sync_out);

    // R6: ready is the cycle before a segment start
    a_r6_ready_then_sync: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> sync_out);

    // R1: a taken byte sets the data-valid bit in the second cycle
    a_r1_dv_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 ser_out);

    // R7: latched speed changes only across a boundary
    a_r7_speed_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> $stable(spd_latched));
endmodule

bind smii_seg_tx smii_seg_tx_chk #(.SEG_W(SEG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_out   (sync_out),
    .ser_out    (ser_out),
    .in_ready   (in_ready),
    .in_valid   (in_valid),
    .spd_latched(spd_latched)
);

// File: tb/sim_smii_seg_tx.sv
module sim_smii_seg_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic speed_100 = 1'b1, crs = 1'b0, in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic link_up = 1'b0, full_duplex = 1'b0, jabber = 1'b0;
    logic in_ready, ser_out, sync_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    smii_seg_tx u0 (
        .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .crs(crs),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .link_up(link_up), .full_duplex(full_duplex), .jabber(jabber),
        .ser_out(ser_out), .sync_out(sync_out)
    );

    // {speed, crs, valid, data, link, duplex, jabber, expected segment}
    localparam logic [23:0] VEC [0:5] = '{
        {1'b1, 1'b1, 1'b1, 8'hA5, 1'b1, 1'b1, 1'b0, 10'h297},
        {1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 10'h01C},
        {1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 10'h025},
        {1'b1, 1'b1, 1'b1, 8'h3C, 1'b1, 1'b1, 1'b0, 10'h0F3},
        {1'b0, 1'b1, 1'b1, 8'h81, 1'b1, 1'b0, 1'b0, 10'h207},
        {1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 10'h010}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Samples one segment copy per repeat, starting at the next negedge
    task automatic capture(input int reps, input logic [9:0] exp, input string req,
                           input bit flip);
        for (int r = 0; r < reps; r++) begin
            logic [9:0] got;
            got = '0;
            for (int b = 0; b < 10; b++) begin
                @(negedge clk);
                if (flip && r == 0 && b == 3) speed_100 = 1'b1;
                got[b] = ser_out;
                check(sync_out == (b == 0), "R3 sync position", sync_out, (b == 0));
                check(in_ready == (b == 9 && r == reps - 1), "R6 ready timing",
                      in_ready, (b == 9 && r == reps - 1));
            end
            check(got == exp, req, got, exp);
        end
    endtask

    // Call at the negedge where rst_n was just released
    task automatic after_reset_check;
        check(sync_out == 1'b1 && ser_out == 1'b0, "R8 first bit after reset",
              {sync_out, ser_out}, 2'b10);
        for (int b = 1; b < 10; b++) begin
            @(negedge clk);
            check(ser_out == 1'b0 && sync_out == 1'b0, "R8 zero segment",
                  {sync_out, ser_out}, 0);
            check(in_ready == (b == 9), "R8 first ready at tenth cycle", in_ready, (b == 9));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sync_out == 1'b1 && ser_out == 1'b0 && in_ready == 1'b0,
              "R8 reset state", {sync_out, ser_out, in_ready}, 3'b100);
        rst_n = 1'b1;
        after_reset_check();

        // Table walk: R1, R2, R4, R5
        for (int i = 0; i < 6; i++) begin
            while (!in_ready) @(negedge clk);
            speed_100   = VEC[i][23];
            crs         = VEC[i][22];
            in_valid    = VEC[i][21];
            in_data     = VEC[i][20:13];
            link_up     = VEC[i][12];
            full_duplex = VEC[i][11];
            jabber      = VEC[i][10];
            capture(VEC[i][23] ? 1 : 10, VEC[i][9:0],
                    VEC[i][21] ? "R1 data segment (R4/R5 repeats)"
                               : "R2 status segment (R4/R5 repeats)", 1'b0);
        end

        // R7: speed flipped mid-segment keeps ten copies
        while (!in_ready) @(negedge clk);
        speed_100 = 1'b0; crs = 1'b0; in_valid = 1'b0;
        link_up = 1'b1; full_duplex = 1'b1; jabber = 1'b0;
        capture(10, 10'h018, "R7 copies kept after mid-segment speed change", 1'b1);
        capture(1, 10'h01C, "R7 new speed takes effect at boundary", 1'b0);

        // R6: byte held valid across repeats is taken once, at the boundary
        while (!in_ready) @(negedge clk);
        speed_100 = 1'b0; crs = 1'b1; in_valid = 1'b0;
        capture(10, 10'h019, "R6 status while idle", 1'b0);
        in_valid = 1'b1; in_data = 8'h5A; speed_100 = 1'b1;
        capture(1, 10'h16B, "R6 byte taken at boundary", 1'b0);
        in_valid = 1'b0;

        // R8: reset in mid-segment
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(sync_out == 1'b1 && ser_out == 1'b0 && in_ready == 1'b0,
              "R8 reset mid-segment", {sync_out, ser_out, in_ready}, 3'b100);
        @(negedge clk);
        speed_100 = 1'b0;
        rst_n = 1'b1;
        after_reset_check();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule